// File: doc/BRIEF.md
# Byte-Order Selectable CRC-16 Engine

This block computes a CRC-16 over a stream of bytes that software delivers as 32-bit words through a small register interface. A control register holds three things: the starting CRC value, the number of bytes to process, and two ordering options. Each data word is then split into four bytes. Depending on one option, the word is taken from its high byte down or from its low byte up. Depending on the other option, each byte goes into the shift register either most significant bit first or least significant bit first. The engine updates the CRC by one byte per clock cycle. Once the programmed number of bytes has been consumed, it ignores further input.

The bus is a simple request/ready port. A transfer completes on a rising clock edge where `req` and `ready` are both high. Reads return data combinationally. Registers sit at word offsets: control at 0x0, data input at 0x4 and result at 0x8. Any other offset reads zero. The engine finishes one word before it accepts the next. A data write that arrives during this time is held off by pulling `ready` low.

Top module: `crc16_order_engine`

## Requirements
- R1: A write to the control register (offset 0x0) loads bits [15:0] into the running CRC, loads bits [25:16] as the remaining byte count, and latches bit 28 (byte order) and bit 29 (bit order). It also abandons any word in progress, so `busy` is low in the next cycle.
- R2: A read of the control register returns the seed in [15:0], the remaining byte count in [25:16], the byte-order select in [28] and the bit-order select in [29]. All other bits read zero.
- R3: Each byte updates the CRC with polynomial 0x1021. The byte is XORed into the high byte, then eight left shifts follow, with no final XOR and no output reflection. For example, seed 0xFFFF over the ASCII bytes "123456789" gives 0x29B1.
- R4: With bit 28 clear, bytes of a word are processed from [31:24] down to [7:0]. With bit 28 set, they are processed from [7:0] up to [31:24].
- R5: With bit 29 clear, bit 7 of each byte enters the CRC first. With bit 29 set, the byte is bit-reversed so that bit 0 enters first.
- R6: An accepted data write (offset 0x4) with a nonzero remaining count raises `busy` on the next cycle. The engine then processes one byte per cycle, for min(4, remaining) cycles. The CRC does not change while `busy` is low, except through a control write.
- R7: The remaining count drops by one for each byte processed. At zero, the rest of the current word and every later data word leave the CRC unchanged, and `busy` stays low, until the control register is written again.
- R8: `ready` is low only for a data write while `busy` is high. Reads, control writes and idle cycles see `ready` high.
- R9: The result register (offset 0x8) reads the current CRC in [15:0] and zero in [31:16], including partway through a word. Writes to it are ignored. The data register reads back the last accepted word.
- R10: After reset, the CRC, seed, count and order selects are zero, and `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Bus transfer request |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 4 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data (combinational) |
| ready | output | 1 | Transfer completes when high with req |
| busy | output | 1 | Bytes of the current word remain to be processed |

## Verification
The hardest case to reach from the ports is a data write queued behind a busy word. A related case is the count running out in the middle of a word, after which the next word must be refused. The stimulus reaches both by issuing data writes back to back, so that the second one stalls on `ready`. It programs byte counts that are not multiples of four, so that the count expires inside a word, and then issues one more word. It also rewrites the control register in the cycle right after a word is accepted, which covers abandoning a word partway through. A behavioural queue model tracks every byte and is compared with `busy`, `ready` and the readable registers on every cycle.

// File: rtl/crc16_order_engine.sv
module crc16_order_engine #(
  parameter int          CNT_W = 10,
  parameter logic [15:0] POLY  = 16'h1021
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        wr,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        ready,
  output logic        busy
);
  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_DATA = 4'h4;
  localparam logic [3:0] OFF_RSLT = 4'h8;
  localparam int         BYTES    = 4;
  localparam int         IDX_W    = $clog2(BYTES);

  logic [15:0]      seed_q, crc_q;
  logic [CNT_W-1:0] rem_q;
  logic             le_q, lsb_q, busy_q;
  logic [31:0]      word_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       cur_byte;
  logic [15:0]      crc_nxt;
  logic [31:0]      ctrl_view;

  wire data_wr  = req && wr && addr == OFF_DATA;
  wire ctrl_wr  = req && wr && addr == OFF_CTRL;
  wire data_acc = data_wr && !busy_q;

  assign ready = !(data_wr && busy_q);
  assign busy  = busy_q;

  always_comb begin
    logic [IDX_W-1:0] sel;
    logic [7:0]       raw;
    sel = le_q ? idx_q : ~idx_q;
    raw = word_q[8*int'(sel) +: 8];
    for (int i = 0; i < 8; i++)
      cur_byte[i] = lsb_q ? raw[7-i] : raw[i];
  end

  always_comb begin
    crc_nxt = crc_q ^ {cur_byte, 8'h00};
    for (int i = 0; i < 8; i++)
      crc_nxt = crc_nxt[15] ? ((crc_nxt << 1) ^ POLY) : (crc_nxt << 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seed_q <= '0;
      crc_q  <= '0;
      rem_q  <= '0;
      le_q   <= 1'b0;
      lsb_q  <= 1'b0;
      busy_q <= 1'b0;
      word_q <= '0;
      idx_q  <= '0;
    end else if (ctrl_wr) begin
      seed_q <= wdata[15:0];
      crc_q  <= wdata[15:0];
      rem_q  <= wdata[16 +: CNT_W];
      le_q   <= wdata[28];
      lsb_q  <= wdata[29];
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (data_acc) begin
      word_q <= wdata;
      idx_q  <= '0;
      busy_q <= rem_q != '0;
    end else if (busy_q) begin
      crc_q <= crc_nxt;
      rem_q <= rem_q - 1'b1;
      idx_q <= idx_q + 1'b1;
      if (idx_q == IDX_W'(BYTES - 1) || rem_q == CNT_W'(1))
        busy_q <= 1'b0;
    end
  end

  always_comb begin
    ctrl_view             = '0;
    ctrl_view[15:0]       = seed_q;
    ctrl_view[16 +: CNT_W] = rem_q;
    ctrl_view[28]         = le_q;
    ctrl_view[29]         = lsb_q;
  end

  always_comb begin
    case (addr)
      OFF_CTRL: rdata = ctrl_view;
      OFF_DATA: rdata = word_q;
      OFF_RSLT: rdata = {16'h0000, crc_q};
      default:  rdata = '0;
    endcase
  end

  AST_CTRL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !busy) else $error("control write left busy high"); // R1
  AST_IDLE_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !ctrl_wr) |=> $stable(crc_q)) else $error("crc moved while idle"); // R6
  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(data_wr)) else $error("busy rose without data write"); // R6
  AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rem_q == '0) |-> !busy_q) else $error("busy with no bytes left"); // R7
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> ready) else $error("ready low while idle"); // R8
  AST_RESULT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFF_RSLT) |-> rdata[31:16] == 16'h0000) else $error("result upper bits set"); // R9
endmodule

// File: tb/test_crc16_order_engine.sv
module test_crc16_order_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [3:0]  addr = 4'h8;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ready, busy;

  int checks = 0, fails = 0;

  crc16_order_engine i_crc16_order_engine (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ready(ready), .busy(busy)
  );

  always #5 clk = ~clk;

  logic [7:0]  q[$];
  logic [15:0] m_crc = '0, m_seed = '0;
  int          m_rem = 0;
  logic        m_le = 1'b0, m_lsb = 1'b0;
  logic [31:0] m_word = '0;

  function automatic logic [15:0] upd(input logic [15:0] c, input logic [7:0] b);
    c = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    return c;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_crc = '0; m_seed = '0; m_rem = 0; m_le = 0; m_lsb = 0; m_word = '0;
    end else if (req && wr && addr == 4'h0) begin
      q.delete(); m_crc = wdata[15:0]; m_seed = wdata[15:0];
      m_rem = int'(wdata[25:16]); m_le = wdata[28]; m_lsb = wdata[29];
    end else if (q.size() != 0) begin
      m_crc = upd(m_crc, q.pop_front());
    end else if (req && wr && addr == 4'h4) begin
      m_word = wdata;
      for (int k = 0; k < 4; k++) begin
        logic [7:0] b;
        b = m_le ? wdata[8*k +: 8] : wdata[8*(3-k) +: 8];
        if (m_rem > 0) begin
          q.push_back(m_lsb ? rev8(b) : b);
          m_rem--;
        end
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic mb;
      mb = q.size() != 0;
      check(busy == mb, "R6 busy", 32'(busy), 32'(mb));
      check(ready == !(req && wr && addr == 4'h4 && mb), "R8 ready", 32'(ready),
            32'(!(req && wr && addr == 4'h4 && mb)));
      if (!(req && wr)) begin
        if (addr == 4'h8) check(rdata == {16'h0, m_crc}, "R9 result", rdata, {16'h0, m_crc});
        if (addr == 4'h4) check(rdata == m_word, "R9 data readback", rdata, m_word);
        if (addr == 4'h0) check(rdata == {2'b00, m_lsb, m_le, 2'b00, 10'(m_rem), m_seed},
                                "R2 control readback", rdata,
                                {2'b00, m_lsb, m_le, 2'b00, 10'(m_rem), m_seed});
      end
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; wr = 1; addr = a; wdata = d;
    #1;
    while (!ready) begin @(negedge clk); #1; end
    @(posedge clk);
    #1 req = 1; wr = 0; addr = 4'h8;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic read_at(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; wr = 0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    addr = 4'h8;
  endtask

  function automatic logic [31:0] ctl(input logic [15:0] s, input int n, input logic le, input logic lsb);
    return {2'b00, lsb, le, 2'b00, 10'(n), s};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    req = 1; wr = 0; addr = 4'h8;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(rdata == 0, "R10 reset result", rdata, 0);
    check(busy == 0, "R10 reset busy", 32'(busy), 0);
    read_at(4'h0, d);
    check(d == 0, "R10 reset control", d, 0);

    // R3 R4 R8: big-endian MSB-first known vector, back-to-back writes stall
    bus_wr(4'h0, ctl(16'hFFFF, 9, 0, 0));
    bus_wr(4'h4, 32'h31323334);
    bus_wr(4'h4, 32'h35363738);
    bus_wr(4'h4, 32'h39AABBCC);
    idle(3);
    read_at(4'h8, d);
    check(d == 32'h29B1, "R3 known vector big-endian", d, 32'h29B1);
    read_at(4'h0, d);
    check(d[25:16] == 0, "R7 count exhausted", d, 0);
    // R7: further word ignored
    bus_wr(4'h4, 32'h12345678);
    idle(2);
    check(busy == 0, "R7 busy stays low", 32'(busy), 0);
    read_at(4'h8, d);
    check(d == 32'h29B1, "R7 word ignored", d, 32'h29B1);

    // R4: little-endian gives the same vector
    bus_wr(4'h0, ctl(16'hFFFF, 9, 1, 0));
    bus_wr(4'h4, 32'h34333231);
    bus_wr(4'h4, 32'h38373635);
    bus_wr(4'h4, 32'hCCBBAA39);
    idle(3);
    read_at(4'h8, d);
    check(d == 32'h29B1, "R4 known vector little-endian", d, 32'h29B1);

    // R5: LSB-first bytes
    bus_wr(4'h0, ctl(16'h0000, 6, 0, 1));
    bus_wr(4'h4, 32'h80010203);
    bus_wr(4'h4, 32'hF00FC3A5);
    idle(3);
    read_at(4'h8, d);
    check(d == {16'h0, m_crc}, "R5 lsb-first result", d, {16'h0, m_crc});

    // R9: write to result register ignored
    bus_wr(4'h8, 32'hDEADBEEF);
    idle(1);
    read_at(4'h8, d);
    check(d == {16'h0, m_crc}, "R9 result write ignored", d, {16'h0, m_crc});

    // R1: control rewrite abandons a word in progress
    bus_wr(4'h0, ctl(16'h1D0F, 20, 0, 0));
    bus_wr(4'h4, 32'hA5A55A5A);
    bus_wr(4'h0, ctl(16'hBEEF, 3, 1, 1));
    #1;
    check(busy == 0, "R1 abort busy", 32'(busy), 0);
    check(rdata == 32'hBEEF, "R1 seed loaded", rdata, 32'hBEEF);
    bus_wr(4'h4, 32'h11223344);
    idle(6);

    // R6 R7: random mix of orders and odd counts
    for (int t = 0; t < 40; t++) begin
      int n;
      n = int'($urandom_range(1, 13));
      bus_wr(4'h0, ctl(16'($urandom), n, 1'($urandom), 1'($urandom)));
      for (int w = 0; w < (n + 7) / 4; w++) bus_wr(4'h4, $urandom);
      idle(int'($urandom_range(0, 5)));
      read_at(4'h0, d);
    end
    idle(6);
    summary();
  end
endmodule